// File: doc/BRIEF.md
# Memory-mapped multiply-accumulate peripheral

This peripheral gives a processor a hardware multiplier that it drives entirely through 16-bit register writes and reads. The operation is never named by a command word. It is implied by which operand-one address software writes. The multiply starts when the second operand is written, and the result words can be read on the cycle after that write.

Two operation sets share the window. The short set takes 16-bit operands and has four modes: unsigned, signed, unsigned accumulate and signed accumulate. It returns a low word, a high word and an extension word. The long set takes 32-bit operands, which are loaded as halves, and returns a 64-bit product as four words. The whole register map answers at two base addresses: 0x0130 and 0x04C0. A register's offset from the base is the same in both windows.

Top module: `mac_periph`

## Requirements
- R1: After reset every readable register returns 0x0000.
- R2: Byte addresses 0x0130–0x015B and 0x04C0–0x04EB both decode the register map, with the same offset selecting the same register. An offset inside the window that names no register reads 0x0000. An address outside both windows reads 0x0000, and a write to it changes nothing.
- R3: A write to offset 0x00, 0x02, 0x04 or 0x06 stores the 16-bit operand one and selects a mode: unsigned multiply, signed multiply, unsigned accumulate or signed accumulate. Any of these four offsets reads back operand one, and offset 0x08 reads back operand two.
- R4: In unsigned multiply mode, a write to 0x08 sets low (0x0A) and high (0x0C) to the unsigned 32-bit product, and sets extension (0x0E) to 0x0000. The new values are readable from the next cycle.
- R5: In signed multiply mode, low and high take the two's-complement product. Extension reads 0xFFFF when the product is negative and 0x0000 otherwise.
- R6: In unsigned accumulate mode, the product is added to {high,low}. The sum wraps to 32 bits, and extension takes the carry out (0x0000 or 0x0001).
- R7: In signed accumulate mode, the signed product is added to {high,low} with a 32-bit wrap. Extension reads 0xFFFF when the new sum is negative and 0x0000 otherwise.
- R8: A write to 0x0A loads the low result word and leaves high unchanged. Later accumulation starts from that value.
- R9: A write to 0x10 or 0x14 sets the 32-bit operand one to the zero-extended value and selects unsigned (0x10) or signed (0x14) 64-bit mode. A write to 0x12 or 0x16 replaces bits 31:16 and keeps bits 15:0. Offsets 0x10 and 0x14 read the low half, and offsets 0x12 and 0x16 read the high half.
- R10: A write to 0x20 sets the 32-bit operand two to the zero-extended value. A write to 0x22 sets its bits 31:16 and starts the 64-bit multiply. Offsets 0x20 and 0x22 read back the two halves.
- R11: The 64-bit product reads at 0x24, 0x26, 0x28 and 0x2A, least significant word first. It is unsigned or two's-complement according to the selected 64-bit mode.
- R12: Result words change only on a trigger write (0x08 or 0x22) or on a preload write (0x0A). Operand writes alone leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
A mode register that latched the wrong selection would not appear at any port until the next trigger write. One cycle after that write, the product would read with the wrong sign or extension word. An accumulator holding a bad value is worse: the error is carried into every later accumulate result until software preloads the low word again. The directed scenarios therefore use operands that give different answers in signed and unsigned modes. They also chain at least two accumulations, so that a carry or a sign error becomes visible in the words read back.

// File: rtl/mac_periph.sv
module mac_periph #(
  parameter logic [15:0] BASE_A = 16'h0130,
  parameter logic [15:0] BASE_B = 16'h04C0,
  parameter int          SPAN   = 44
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata
);
  localparam logic [15:0] END_A = BASE_A + 16'(SPAN);
  localparam logic [15:0] END_B = BASE_B + 16'(SPAN);

  logic [15:0] op1, op2, reslo, reshi, ext;
  logic [1:0]  mode16;
  logic [31:0] op1_w, op2_w;
  logic        sgn64;
  logic [63:0] res64;

  logic in_a, in_b, hit, wr;
  logic [5:0] off;
  assign in_a = (bus_addr >= BASE_A) && (bus_addr < END_A);
  assign in_b = (bus_addr >= BASE_B) && (bus_addr < END_B);
  assign hit  = in_a || in_b;
  assign off  = in_a ? 6'(bus_addr - BASE_A) : 6'(bus_addr - BASE_B);
  assign wr   = bus_we && hit;

  logic [31:0] acc, pu, ps, ssum;
  logic [32:0] usum;
  logic [31:0] opnd_w;
  logic [63:0] pu64, ps64;
  assign acc    = {reshi, reslo};
  assign pu     = {16'b0, op1} * {16'b0, bus_wdata};
  assign ps     = {{16{op1[15]}}, op1} * {{16{bus_wdata[15]}}, bus_wdata};
  assign usum   = {1'b0, acc} + {1'b0, pu};
  assign ssum   = acc + ps;
  assign opnd_w = {bus_wdata, op2_w[15:0]};
  assign pu64   = {32'b0, op1_w} * {32'b0, opnd_w};
  assign ps64   = {{32{op1_w[31]}}, op1_w} * {{32{opnd_w[31]}}, opnd_w};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op1 <= '0; op2 <= '0; reslo <= '0; reshi <= '0; ext <= '0;
      mode16 <= '0; op1_w <= '0; op2_w <= '0; sgn64 <= 1'b0; res64 <= '0;
    end else if (wr) begin
      case (off)
        6'h00, 6'h02, 6'h04, 6'h06: begin
          op1 <= bus_wdata;
          mode16 <= off[2:1];
        end
        6'h08: begin
          op2 <= bus_wdata;
          case (mode16)
            2'd0: begin {reshi, reslo} <= pu; ext <= '0; end
            2'd1: begin {reshi, reslo} <= ps; ext <= {16{ps[31]}}; end
            2'd2: begin {reshi, reslo} <= usum[31:0]; ext <= {15'b0, usum[32]}; end
            default: begin {reshi, reslo} <= ssum; ext <= {16{ssum[31]}}; end
          endcase
        end
        6'h0A: reslo <= bus_wdata;
        6'h10, 6'h14: begin
          op1_w <= {16'b0, bus_wdata};
          sgn64 <= off[2];
        end
        6'h12, 6'h16: op1_w[31:16] <= bus_wdata;
        6'h20: op2_w <= {16'b0, bus_wdata};
        6'h22: begin
          op2_w[31:16] <= bus_wdata;
          res64 <= sgn64 ? ps64 : pu64;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (off)
        6'h00, 6'h02, 6'h04, 6'h06: bus_rdata = op1;
        6'h08: bus_rdata = op2;
        6'h0A: bus_rdata = reslo;
        6'h0C: bus_rdata = reshi;
        6'h0E: bus_rdata = ext;
        6'h10, 6'h14: bus_rdata = op1_w[15:0];
        6'h12, 6'h16: bus_rdata = op1_w[31:16];
        6'h20: bus_rdata = op2_w[15:0];
        6'h22: bus_rdata = op2_w[31:16];
        6'h24: bus_rdata = res64[15:0];
        6'h26: bus_rdata = res64[31:16];
        6'h28: bus_rdata = res64[47:32];
        6'h2A: bus_rdata = res64[63:48];
        default: bus_rdata = '0;
      endcase
    end
  end

  assert_umpy_ext_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == 6'h08 && mode16 == 2'd0) |=> (ext == 16'h0000));

  assert_signed_ext_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == 6'h08 && mode16[0]) |=> (ext == 16'h0000 || ext == 16'hFFFF));

  assert_high_load_keeps_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (off == 6'h12 || off == 6'h16)) |=> (op1_w[15:0] == $past(op1_w[15:0])));

  assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> ($stable(reslo) && $stable(reshi) && $stable(res64) && $stable(op1)));

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && off == 6'h22) |=> $stable(res64));

endmodule

// File: tb/mac_periph_bench.sv
module mac_periph_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mac_periph u_mac_periph (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [15:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1", 16'h0130, 16'h0000);
    chk("R1", 16'h013A, 16'h0000);
    chk("R1", 16'h013C, 16'h0000);
    chk("R1", 16'h013E, 16'h0000);
    chk("R1", 16'h0154, 16'h0000);
    chk("R1", 16'h015A, 16'h0000);
  endtask

  task automatic t_umpy;
    wr(16'h0130, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    chk("R4", 16'h013A, 16'h0001);
    chk("R4", 16'h013C, 16'hFFFE);
    chk("R4", 16'h013E, 16'h0000);
    chk("R3", 16'h0130, 16'hFFFF);
    chk("R3", 16'h0138, 16'hFFFF);
  endtask

  task automatic t_smpy;
    wr(16'h0132, 16'hFFFE);
    wr(16'h0138, 16'h0003);
    chk("R5", 16'h013A, 16'hFFFA);
    chk("R5", 16'h013C, 16'hFFFF);
    chk("R5", 16'h013E, 16'hFFFF);
    wr(16'h0138, 16'hFFFF);
    chk("R5", 16'h013A, 16'h0002);
    chk("R5", 16'h013C, 16'h0000);
    chk("R5", 16'h013E, 16'h0000);
  endtask

  task automatic t_umac;
    wr(16'h0134, 16'hFFFF);
    wr(16'h013A, 16'h0002);
    chk("R8", 16'h013A, 16'h0002);
    chk("R8", 16'h013C, 16'h0000);
    wr(16'h0138, 16'hFFFF);
    chk("R6", 16'h013A, 16'h0003);
    chk("R6", 16'h013C, 16'hFFFE);
    chk("R6", 16'h013E, 16'h0000);
    wr(16'h0138, 16'hFFFF);
    chk("R6", 16'h013A, 16'h0004);
    chk("R6", 16'h013C, 16'hFFFC);
    chk("R6", 16'h013E, 16'h0001);
  endtask

  task automatic t_smac;
    wr(16'h0136, 16'hFFFF);
    wr(16'h013A, 16'h0000);
    wr(16'h0138, 16'h0005);
    chk("R7", 16'h013A, 16'hFFFB);
    chk("R7", 16'h013C, 16'hFFFB);
    chk("R7", 16'h013E, 16'hFFFF);
  endtask

  task automatic t_mirror;
    wr(16'h04C0, 16'h0007);
    wr(16'h04C8, 16'h0006);
    chk("R2", 16'h013A, 16'h002A);
    chk("R2", 16'h04CA, 16'h002A);
    chk("R2", 16'h04CE, 16'h0000);
    chk("R2", 16'h0130, 16'h0007);
    chk("R2", 16'h0148, 16'h0000);
    chk("R2", 16'h012E, 16'h0000);
    chk("R2", 16'h015C, 16'h0000);
    wr(16'h012E, 16'h1234);
    wr(16'h04EC, 16'h1234);
    chk("R2", 16'h013A, 16'h002A);
    chk("R2", 16'h0130, 16'h0007);
  endtask

  task automatic t_hold;
    wr(16'h0130, 16'h0003);
    chk("R12", 16'h013A, 16'h002A);
    chk("R12", 16'h0130, 16'h0003);
  endtask

  task automatic t_mul32u;
    wr(16'h0140, 16'hFFFF);
    wr(16'h0142, 16'hFFFF);
    chk("R9", 16'h0140, 16'hFFFF);
    chk("R9", 16'h0142, 16'hFFFF);
    wr(16'h0150, 16'h0002);
    wr(16'h0152, 16'h0000);
    chk("R11", 16'h0154, 16'hFFFE);
    chk("R11", 16'h0156, 16'hFFFF);
    chk("R11", 16'h0158, 16'h0001);
    chk("R11", 16'h015A, 16'h0000);
    wr(16'h0140, 16'h0005);
    chk("R9", 16'h0142, 16'h0000);
    chk("R9", 16'h0140, 16'h0005);
  endtask

  task automatic t_mul32s;
    wr(16'h0144, 16'hFFFF);
    wr(16'h0146, 16'hFFFF);
    chk("R9", 16'h0144, 16'hFFFF);
    wr(16'h0150, 16'h0003);
    wr(16'h0152, 16'h0000);
    chk("R11", 16'h0154, 16'hFFFD);
    chk("R11", 16'h0156, 16'hFFFF);
    chk("R11", 16'h0158, 16'hFFFF);
    chk("R11", 16'h015A, 16'hFFFF);
    chk("R2", 16'h04E4, 16'hFFFD);
    wr(16'h0152, 16'h0001);
    wr(16'h0150, 16'h0007);
    chk("R10", 16'h0152, 16'h0000);
    chk("R10", 16'h0150, 16'h0007);
    chk("R12", 16'h0154, 16'hFFFD);
  endtask

  task automatic t_signdiff;
    wr(16'h0144, 16'h0000);
    wr(16'h0146, 16'h8000);
    wr(16'h0150, 16'hFFFF);
    wr(16'h0152, 16'hFFFF);
    chk("R11", 16'h0154, 16'h0000);
    chk("R11", 16'h0156, 16'h8000);
    chk("R11", 16'h0158, 16'h0000);
    chk("R11", 16'h015A, 16'h0000);
    wr(16'h0140, 16'h0000);
    wr(16'h0142, 16'h8000);
    wr(16'h0152, 16'hFFFF);
    chk("R11", 16'h0154, 16'h0000);
    chk("R11", 16'h0156, 16'h8000);
    chk("R11", 16'h0158, 16'hFFFF);
    chk("R11", 16'h015A, 16'h7FFF);
    chk("R10", 16'h0152, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_umpy;
    t_smpy;
    t_umac;
    t_smac;
    t_mirror;
    t_hold;
    t_mul32u;
    t_mul32s;
    t_signdiff;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule